// File: doc/BRIEF.md
# Dual-Identity Two-Wire Slave

This block is a two-wire serial bus slave that runs entirely in the system clock domain. It oversamples the clock and data lines, detects START and STOP conditions, and takes in the first byte of each transfer as an address. One bus slave answers under two separate 4-bit identities: a memory back end and a register companion. Each identity leads to its own logical back end, and both are also qualified by two external select pins.

Once it has accepted an address, the block moves bytes in either direction, most significant bit first, and handles acknowledges. Back-end controllers see only byte-level strobes:

- a select strobe, which gives the chosen device and the transfer direction;
- a strobe for each received byte;
- a strobe that reports the transmit byte has been taken and asks for the next one.

A back end can also refuse a byte. The slave never drives the data line high. It only enables a low drive.

Top module: `twowire_dual_slave`

## Requirements
- R1: The address byte arrives MSB first. Upper nibble 1010b selects the memory (sel_dev_o=0) and 1101b selects the companion (sel_dev_o=1). For either, the slave pulls SDA low in the acknowledge slot and pulses sel_o. Any other upper nibble gets no acknowledge, and the slave gives no strobe and no acknowledge until the next START.
- R2: Address bits 2..1 must equal dev_pins_i[1:0], or the slave ignores the transfer. Address bit 3 has no effect on matching.
- R3: Address bit 0 is the direction: 1 means read and 0 means write. It is reported on sel_rd_o together with sel_o.
- R4: On a write, each data byte is shifted in MSB first. rx_valid_o then pulses with the byte on rx_data_o, and the slave pulls SDA low during the acknowledge slot that follows.
- R5: On a read, the slave takes tx_data_i and pulses tx_next_o at the end of the address acknowledge. It then drives that byte onto SDA MSB first.
- R6: During a read, a low acknowledge from the master makes the slave take and send the next tx_data_i byte. A high (absent) acknowledge makes it release SDA and send nothing until the next START.
- R7: If nack_req_i is high while a data byte is in progress, the slave leaves SDA released in that byte's acknowledge slot. It then ignores the bus until the next START, and a write byte is still reported on rx_valid_o.
- R8: A repeated START returns the slave to the address phase. A STOP returns it to idle from any state. Both release SDA.
- R9: The SDA drive enable changes only while SCL is low.
- R10: sel_o, rx_valid_o and tx_next_o are single-cycle pulses and never coincide. All three are low after reset, as is sda_oe_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| dev_pins_i | input | 2 | Board-strapped select value compared with address bits 2..1 |
| sel_o | output | 1 | Pulse: address accepted |
| sel_dev_o | output | 1 | Selected device: 0 memory, 1 companion |
| sel_rd_o | output | 1 | Direction of the selected transfer: 1 read |
| rx_valid_o | output | 1 | Pulse: rx_data_o holds a received byte |
| rx_data_o | output | 8 | Last received data byte |
| tx_data_i | input | 8 | Byte to transmit next |
| tx_next_o | output | 1 | Pulse: tx_data_i taken, present the following byte |
| nack_req_i | input | 1 | Back-end request to refuse the current byte |

## Verification
The address byte is tried with both identities, with bit 3 set and clear, with a foreign identity and with a pin mismatch. This separates decoding of the nibble, the pins and the don't-care bit. Writes use bytes with mixed bit patterns, so that a reversed bit order or a lost bit shows up in rx_data_o. Reads run ACK, ACK, NACK and then clock one more byte, which distinguishes correct continuation from a slave that keeps talking after the master declines. Further cases cover a repeated START into the companion, a STOP in the middle of a byte and a back-end refusal. Together they show that each exit lands in the right phase and that the following START recovers the slave.

// File: rtl/twd_pkg.sv
package twd_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ID_W   = 4;
  localparam int unsigned PIN_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_IGNORE
  } twd_state_e;
endpackage

// File: rtl/twd_line_sync.sv
module twd_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // idle bus lines are high, so reset to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign line_o = chain_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/twd_addr_match.sv
module twd_addr_match #(
  parameter logic [twd_pkg::ID_W-1:0] ID_MEM  = 4'b1010,
  parameter logic [twd_pkg::ID_W-1:0] ID_COMP = 4'b1101
) (
  input  logic [twd_pkg::ID_W-1:0]  id_i,
  input  logic [twd_pkg::PIN_W-1:0] sel_bits_i,
  input  logic                      rw_i,
  input  logic [twd_pkg::PIN_W-1:0] pins_i,
  output logic                      hit_o,
  output logic                      dev_o,
  output logic                      rd_o
);
  logic mem_hit, comp_hit, pin_ok;

  always_comb begin
    mem_hit  = (id_i == ID_MEM);
    comp_hit = (id_i == ID_COMP);
    pin_ok   = (sel_bits_i == pins_i);
    hit_o    = pin_ok && (mem_hit || comp_hit);
    dev_o    = comp_hit;
    rd_o     = rw_i;
  end
endmodule

// File: rtl/twd_byte_engine.sv
module twd_byte_engine
  import twd_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          hit_i,
  input  logic          dev_i,
  input  logic          rd_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          nack_req_i,
  output logic [DW-1:0] sr_o,
  output logic          sda_oe_o,
  output logic          sel_o,
  output logic          sel_dev_o,
  output logic          sel_rd_o,
  output logic          rx_valid_o,
  output logic [DW-1:0] rx_data_o,
  output logic          tx_next_o
);
  localparam int unsigned CNT_W = $clog2(DW + 1);

  twd_state_e      st_q;
  logic [DW-1:0]   sr_q, rx_q;
  logic [CNT_W-1:0] cnt_q;
  logic            oe_q, dev_q, rd_q, ack_ok_q, nack_q;
  logic            sel_q, rx_v_q, tx_n_q;
  logic            full, refuse;

  assign full   = (cnt_q == CNT_W'(DW));
  assign refuse = nack_q | nack_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      sr_q     <= '0;
      rx_q     <= '0;
      cnt_q    <= '0;
      oe_q     <= 1'b0;
      dev_q    <= 1'b0;
      rd_q     <= 1'b0;
      ack_ok_q <= 1'b0;
      nack_q   <= 1'b0;
      sel_q    <= 1'b0;
      rx_v_q   <= 1'b0;
      tx_n_q   <= 1'b0;
    end else begin
      sel_q  <= 1'b0;
      rx_v_q <= 1'b0;
      tx_n_q <= 1'b0;
      if (nack_req_i && (st_q == ST_WR || st_q == ST_RD)) nack_q <= 1'b1;

      if (stop_i) begin
        st_q   <= ST_IDLE;
        oe_q   <= 1'b0;
        nack_q <= 1'b0;
      end else if (start_i) begin
        st_q   <= ST_ADDR;
        oe_q   <= 1'b0;
        cnt_q  <= '0;
        nack_q <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sr_q  <= {sr_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + CNT_W'(1);
            end else if (scl_fall_i && full) begin
              if (hit_i) begin
                st_q  <= ST_ADDR_ACK;
                oe_q  <= 1'b1;
                sel_q <= 1'b1;
                dev_q <= dev_i;
                rd_q  <= rd_i;
              end else begin
                st_q <= ST_IGNORE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rd_q) begin
                sr_q   <= tx_data_i;
                oe_q   <= ~tx_data_i[DW-1];
                tx_n_q <= 1'b1;
                st_q   <= ST_RD;
              end else begin
                oe_q <= 1'b0;
                st_q <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise_i) begin
              sr_q  <= {sr_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + CNT_W'(1);
            end else if (scl_fall_i && full) begin
              rx_q   <= sr_q;
              rx_v_q <= 1'b1;
              if (refuse) begin
                st_q <= ST_IGNORE;
              end else begin
                oe_q <= 1'b1;
                st_q <= ST_WR_ACK;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              oe_q  <= 1'b0;
              cnt_q <= '0;
              st_q  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + CNT_W'(1);
            end else if (scl_fall_i) begin
              if (full) begin
                oe_q     <= 1'b0;
                ack_ok_q <= 1'b0;
                st_q     <= refuse ? ST_IGNORE : ST_RD_ACK;
              end else begin
                sr_q <= {sr_q[DW-2:0], 1'b0};
                oe_q <= ~sr_q[DW-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              if (sda_i) st_q <= ST_IGNORE;
              else       ack_ok_q <= 1'b1;
            end else if (scl_fall_i && ack_ok_q) begin
              sr_q   <= tx_data_i;
              oe_q   <= ~tx_data_i[DW-1];
              tx_n_q <= 1'b1;
              cnt_q  <= '0;
              st_q   <= ST_RD;
            end
          end
          ST_IDLE, ST_IGNORE: ;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sr_o       = sr_q;
  assign sda_oe_o   = oe_q;
  assign sel_o      = sel_q;
  assign sel_dev_o  = dev_q;
  assign sel_rd_o   = rd_q;
  assign rx_valid_o = rx_v_q;
  assign rx_data_o  = rx_q;
  assign tx_next_o  = tx_n_q;
endmodule

// File: rtl/twowire_dual_slave.sv
module twowire_dual_slave
  import twd_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_MEM      = 4'b1010,
  parameter logic [ID_W-1:0] ID_COMP     = 4'b1101,
  parameter int unsigned     SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [PIN_W-1:0]  dev_pins_i,
  output logic              sel_o,
  output logic              sel_dev_o,
  output logic              sel_rd_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              tx_next_o,
  input  logic              nack_req_i
);
  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic hit, dev, rd;
  logic [BYTE_W-1:0] sr;

  twd_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i), .line_o(scl_s), .prev_o(scl_p)
  );
  twd_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i), .line_o(sda_s), .prev_o(sda_p)
  );

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // SDA edges while SCL stays high are bus conditions
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  twd_addr_match #(.ID_MEM(ID_MEM), .ID_COMP(ID_COMP)) u_match (
    .id_i      (sr[BYTE_W-1 -: ID_W]),
    .sel_bits_i(sr[PIN_W:1]),
    .rw_i      (sr[0]),
    .pins_i    (dev_pins_i),
    .hit_o     (hit),
    .dev_o     (dev),
    .rd_o      (rd)
  );

  twd_byte_engine #(.DW(BYTE_W)) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_i     (sda_s),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .hit_i     (hit),
    .dev_i     (dev),
    .rd_i      (rd),
    .tx_data_i (tx_data_i),
    .nack_req_i(nack_req_i),
    .sr_o      (sr),
    .sda_oe_o  (sda_oe_o),
    .sel_o     (sel_o),
    .sel_dev_o (sel_dev_o),
    .sel_rd_o  (sel_rd_o),
    .rx_valid_o(rx_valid_o),
    .rx_data_o (rx_data_o),
    .tx_next_o (tx_next_o)
  );
endmodule

// File: rtl/twd_checker.sv
module twd_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic sel_o,
  input logic rx_valid_o,
  input logic tx_next_o
);
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe) |-> !scl_s);  // R9

  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe);  // R8

  AST_START_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe);  // R8

  AST_SEL_ACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |-> sda_oe);  // R1

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_o, rx_valid_o, tx_next_o}));  // R10

  AST_SEL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |=> !sel_o);  // R10

  AST_TX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_next_o |=> !tx_next_o);  // R10
endmodule

bind twowire_dual_slave twd_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe_o),
  .sel_o     (sel_o),
  .rx_valid_o(rx_valid_o),
  .tx_next_o (tx_next_o)
);

// File: tb/sim_twowire_dual_slave.sv
module sim_twowire_dual_slave;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] pins = 2'b10;
  logic nack_req = 1'b0;
  logic sda_oe, sel, sel_dev, sel_rd, rx_valid, tx_next;
  logic [7:0] rx_data, tx_data;
  logic sda_bus;

  int checks = 0;
  int fails = 0;
  int sel_cnt = 0;
  int rx_cnt = 0;
  int tx_idx = 0;
  logic last_dev = 1'b0;
  logic last_rd = 1'b0;
  logic [7:0] rx_q[$];
  logic prev_oe = 1'b0;
  bit done = 1'b0;

  logic [7:0] tx_bytes [8] = '{8'h96, 8'h3C, 8'hF0, 8'h5B, 8'h81, 8'h7E, 8'h24, 8'hC9};

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain bus: either side may pull low
  assign sda_bus = sda_m & ~sda_oe;
  assign tx_data = tx_bytes[tx_idx % 8];

  twowire_dual_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .dev_pins_i(pins), .sel_o(sel), .sel_dev_o(sel_dev), .sel_rd_o(sel_rd),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .tx_data_i(tx_data),
    .tx_next_o(tx_next), .nack_req_i(nack_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock observer: strobes, drive timing
  always @(negedge clk) begin
    if (rst_n) begin
      if (sel) begin sel_cnt++; last_dev = sel_dev; last_rd = sel_rd; end
      if (rx_valid) begin rx_cnt++; rx_q.push_back(rx_data); end
      if (tx_next) tx_idx++;
      if (int'(sel) + int'(rx_valid) + int'(tx_next) > 1)
        check("R10 strobes overlap", 1, 0);
      if (sda_oe !== prev_oe) check("R9 drive change with SCL high", scl_m, 0);
      prev_oe = sda_oe;
    end
  end

  task automatic bit_xfer(input logic b, output logic r);
    repeat (2) @(negedge clk);
    sda_m = b;
    repeat (6) @(negedge clk);
    scl_m = 1'b1;
    repeat (4) @(negedge clk);
    r = sda_bus;
    repeat (4) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic start_cond();
    sda_m = 1'b1;
    repeat (4) @(negedge clk);
    scl_m = 1'b1;
    repeat (4) @(negedge clk);
    sda_m = 1'b0;
    repeat (4) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic stop_cond();
    repeat (2) @(negedge clk);
    sda_m = 1'b0;
    repeat (4) @(negedge clk);
    scl_m = 1'b1;
    repeat (4) @(negedge clk);
    sda_m = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(d[i], r);
    bit_xfer(1'b1, r);
    ack = ~r;
  endtask

  task automatic read_byte(output logic [7:0] d, input logic m_ack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, r);
      d[i] = r;
    end
    bit_xfer(~m_ack, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int base_sel, base_rx, base_tx;

    repeat (3) @(negedge clk);
    check("R10 reset oe", sda_oe, 0);
    check("R10 reset strobes", {sel, rx_valid, tx_next}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // memory write, two bytes
    start_cond();
    write_byte(8'hA4, ack);
    check("R1 memory address ack", ack, 1);
    check("R1 sel count", sel_cnt, 1);
    check("R1 device is memory", last_dev, 0);
    check("R3 direction write", last_rd, 0);
    write_byte(8'h5A, ack);
    check("R4 write ack 1", ack, 1);
    write_byte(8'hC3, ack);
    check("R4 write ack 2", ack, 1);
    stop_cond();
    check("R4 rx count", rx_cnt, 2);
    check("R4 rx byte 1", rx_q.pop_front(), 8'h5A);
    check("R4 rx byte 2", rx_q.pop_front(), 8'hC3);

    // companion, bit 3 set
    start_cond();
    write_byte(8'hDC, ack);
    check("R2 companion with bit3 set ack", ack, 1);
    check("R1 device is companion", last_dev, 1);
    write_byte(8'h01, ack);
    check("R4 companion write ack", ack, 1);
    stop_cond();
    check("R4 companion rx byte", rx_q.pop_front(), 8'h01);

    // foreign identity
    base_sel = sel_cnt; base_rx = rx_cnt;
    start_cond();
    write_byte(8'hB4, ack);
    check("R1 foreign id no ack", ack, 0);
    write_byte(8'h00, ack);
    check("R1 ignored data no ack", ack, 0);
    stop_cond();
    check("R1 foreign id no strobes", sel_cnt - base_sel + rx_cnt - base_rx, 0);

    // pin mismatch
    start_cond();
    write_byte(8'hA2, ack);
    check("R2 pin mismatch no ack", ack, 0);
    stop_cond();
    check("R2 pin mismatch no sel", sel_cnt - base_sel, 0);

    // memory read ACK ACK NACK then one extra byte
    base_tx = tx_idx;
    start_cond();
    write_byte(8'hA5, ack);
    check("R1 read address ack", ack, 1);
    check("R3 direction read", last_rd, 1);
    read_byte(d, 1'b1);
    check("R5 read byte 1", d, tx_bytes[base_tx % 8]);
    read_byte(d, 1'b1);
    check("R6 read byte 2 after ack", d, tx_bytes[(base_tx + 1) % 8]);
    read_byte(d, 1'b0);
    check("R6 read byte 3", d, tx_bytes[(base_tx + 2) % 8]);
    read_byte(d, 1'b0);
    check("R6 released after master nack", d, 8'hFF);
    check("R6 no fetch after nack", tx_idx - base_tx, 3);
    stop_cond();

    // repeated start into companion read
    start_cond();
    write_byte(8'hA4, ack);
    write_byte(8'h11, ack);
    check("R4 write before restart", ack, 1);
    base_tx = tx_idx;
    start_cond();
    write_byte(8'hDD, ack);
    check("R8 restart address ack", ack, 1);
    check("R8 restart companion read", {last_dev, last_rd}, 2'b11);
    read_byte(d, 1'b0);
    check("R5 companion read byte", d, tx_bytes[base_tx % 8]);
    stop_cond();
    void'(rx_q.pop_front());

    // back-end refusal
    start_cond();
    write_byte(8'hA4, ack);
    base_rx = rx_cnt;
    nack_req = 1'b1;
    write_byte(8'hE7, ack);
    nack_req = 1'b0;
    check("R7 refused byte not acked", ack, 0);
    check("R7 refused byte still reported", rx_cnt - base_rx, 1);
    check("R7 refused byte value", rx_q.pop_front(), 8'hE7);
    write_byte(8'h42, ack);
    check("R7 ignored after refusal", ack, 0);
    check("R7 no rx after refusal", rx_cnt - base_rx, 1);
    start_cond();
    write_byte(8'hA4, ack);
    check("R7 recovers on start", ack, 1);
    stop_cond();

    // stop in the middle of a byte
    start_cond();
    write_byte(8'hA4, ack);
    base_rx = rx_cnt;
    for (int i = 0; i < 3; i++) bit_xfer(1'b1, ack);
    stop_cond();
    check("R8 stop mid byte no rx", rx_cnt - base_rx, 0);
    check("R8 idle after stop", sda_oe, 0);
    start_cond();
    write_byte(8'hDC, ack);
    check("R8 address after stop", ack, 1);
    stop_cond();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule